// File: doc/BRIEF.md
# Root Port PME Status Tracker

This block records power-management event messages that reach a PCI Express root port and presents them to software through one 32-bit status register. A new event sets a status flag and latches the 16-bit requester ID of its sender. Events that arrive while the flag is set wait in a small queue. When software writes one to the status bit to clear it, the oldest waiting event is reported next.

Transitions of the status flag drive the outward signalling. A rising edge raises a level interrupt and sends a one-cycle request to emit an assert-GPE message. A falling edge lowers the interrupt and sends a one-cycle deassert-GPE request. Each kind of signalling has its own enable input. The register port has no address, because it reaches only this one register. A read returns the value one cycle after the request.

Top module: `pme_status_tracker`

## Requirements
- R1: After reset the register value is zero, the interrupt, both GPE request outputs and the overflow flag are low, and `reg_rdata` is zero.
- R2: A read returns, one cycle after `reg_rd`, bits 15:0 = requester ID, bit 16 = status flag, bit 17 = pending flag, bits 31:18 = zero.
- R3: An event that arrives while status is clear and nothing is queued sets status and loads its requester ID at the next clock edge.
- R4: An event that arrives while status is set leaves status and ID unchanged, enters the queue, and makes the pending flag read 1.
- R5: Writing 1 to bit 16 clears status. Writing 0 there, or writing any other bit, changes nothing.
- R6: If the queue holds events when status is cleared, status reads 0 for exactly one cycle and is then set again with the oldest queued ID (first in, first out).
- R7: The pending flag reads 0 as soon as the queue is empty.
- R8: The queue holds 4 IDs. An event that arrives while the queue is full is dropped and sets `overflow`, which stays set until reset.
- R9: An event that arrives in the same cycle as a clear, with the queue empty, is never queued (pending stays 0). Status reads 0 for one cycle with the new ID already loaded, then reads 1.
- R10: While `int_en` is high, `irq` rises with every 0-to-1 change of status and falls with every 1-to-0 change. While `int_en` is low, `irq` holds its value.
- R11: While `gpe_en` is high, `gpe_assert_req` pulses for one cycle on each 0-to-1 change of status and `gpe_deassert_req` pulses on each 1-to-0 change. While `gpe_en` is low, neither pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle strobe: an event message arrived |
| evt_rid | input | 16 | Requester ID of the arriving event |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data (only bit 16 acts, as write-one-to-clear) |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |
| int_en | input | 1 | Interrupt enable |
| gpe_en | input | 1 | GPE message enable |
| irq | output | 1 | Level interrupt |
| gpe_assert_req | output | 1 | One-cycle request to send assert-GPE |
| gpe_deassert_req | output | 1 | One-cycle request to send deassert-GPE |
| overflow | output | 1 | Sticky flag: a queued event was dropped |

## Verification
A corrupt queue pointer shows up in the second read after the next clear: that read returns a wrong or repeated requester ID, or a pending bit that disagrees with the number of events sent. A status flag stuck in one state shows at once on `irq` and on the GPE pulses, which should change in the edge right after a clear or an arrival. The re-delivery gap is checked cycle by cycle, because a missing low cycle would hide one deassert pulse. The drop on a full queue is seen through `overflow` one edge after the fifth queued event, and later through the delivered IDs, which must skip the dropped one.

// File: rtl/pme_pkg.sv
package pme_pkg;
    localparam int RID_W   = 16;
    localparam int REG_W   = 32;
    localparam int STAT_BIT = RID_W;
    localparam int PEND_BIT = RID_W + 1;
    localparam int RSVD_W  = REG_W - RID_W - 2;

    typedef logic [RID_W-1:0] rid_t;
endpackage

// File: rtl/pme_rid_fifo.sv
module pme_rid_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign dout  = mem_q[s_q.rp];

    always_comb begin
        s_d = s_q;
        if (push) s_d.wp = bump(s_q.wp);
        if (pop)  s_d.rp = bump(s_q.rp);
        if (push && !pop)      s_d.cnt = s_q.cnt + 1'b1;
        else if (pop && !push) s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[s_q.wp] <= din;
    end
endmodule

// File: rtl/pme_notify.sv
module pme_notify (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_cur,
    input  logic stat_nxt,
    input  logic int_en,
    input  logic gpe_en,
    output logic irq,
    output logic gpe_assert_req,
    output logic gpe_deassert_req
);
    typedef struct packed {
        logic irq;
        logic ga;
        logic gd;
    } ntf_t;

    ntf_t n_d, n_q;
    logic rise, fall;

    assign rise = stat_nxt & ~stat_cur;
    assign fall = stat_cur & ~stat_nxt;

    always_comb begin
        n_d     = n_q;
        n_d.ga  = gpe_en & rise;
        n_d.gd  = gpe_en & fall;
        if (int_en && rise)      n_d.irq = 1'b1;
        else if (int_en && fall) n_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    assign irq              = n_q.irq;
    assign gpe_assert_req   = n_q.ga;
    assign gpe_deassert_req = n_q.gd;
endmodule

// File: rtl/pme_status_tracker.sv
module pme_status_tracker
    import pme_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [RID_W-1:0] evt_rid,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             reg_rd,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             int_en,
    input  logic             gpe_en,
    output logic             irq,
    output logic             gpe_assert_req,
    output logic             gpe_deassert_req,
    output logic             overflow
);
    typedef struct packed {
        logic             stat;
        logic             hold;
        rid_t             rid;
        logic             ovf;
        logic [REG_W-1:0] rdata;
    } trk_t;

    trk_t t_d, t_q;

    logic fifo_push, fifo_pop, fifo_empty, fifo_full, want_push, clr;
    rid_t fifo_dout;
    logic status_bit, pending_bit;
    logic unused_wdata;

    assign unused_wdata = ^{reg_wdata[REG_W-1:STAT_BIT+1], reg_wdata[STAT_BIT-1:0]};
    assign clr          = reg_wr & reg_wdata[STAT_BIT] & t_q.stat;
    assign status_bit   = t_q.stat;
    assign pending_bit  = ~fifo_empty;

    always_comb begin
        t_d       = t_q;
        want_push = 1'b0;
        fifo_pop  = 1'b0;
        if (t_q.stat) begin
            if (clr) begin
                t_d.stat = 1'b0;
                if (evt_valid && fifo_empty) begin
                    t_d.rid  = evt_rid;
                    t_d.hold = 1'b1;
                end else begin
                    want_push = evt_valid;
                end
            end else begin
                want_push = evt_valid;
            end
        end else if (t_q.hold) begin
            t_d.stat  = 1'b1;
            t_d.hold  = 1'b0;
            want_push = evt_valid;
        end else if (!fifo_empty) begin
            fifo_pop  = 1'b1;
            t_d.stat  = 1'b1;
            t_d.rid   = fifo_dout;
            want_push = evt_valid;
        end else if (evt_valid) begin
            t_d.stat = 1'b1;
            t_d.rid  = evt_rid;
        end

        fifo_push = want_push & (~fifo_full | fifo_pop);
        if (want_push && !fifo_push) t_d.ovf = 1'b1;

        if (reg_rd) t_d.rdata = {{RSVD_W{1'b0}}, pending_bit, t_q.stat, t_q.rid};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    pme_rid_fifo #(.W(RID_W), .DEPTH(QDEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (evt_rid),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    pme_notify u_notify (
        .clk              (clk),
        .rst_n            (rst_n),
        .stat_cur         (t_q.stat),
        .stat_nxt         (t_d.stat),
        .int_en           (int_en),
        .gpe_en           (gpe_en),
        .irq              (irq),
        .gpe_assert_req   (gpe_assert_req),
        .gpe_deassert_req (gpe_deassert_req)
    );

    assign reg_rdata = t_q.rdata;
    assign overflow  = t_q.ovf;
endmodule

// File: rtl/pme_status_checker.sv
module pme_status_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        int_en,
    input logic        gpe_en,
    input logic        status,
    input logic        pending,
    input logic        irq,
    input logic        gpe_assert_req,
    input logic        gpe_deassert_req,
    input logic        overflow,
    input logic [31:0] reg_rdata
);
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:18] == '0);

    p_redeliver_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!status && pending) |=> status);

    p_sticky_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en && !status) |=> (!status || irq));

    p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en && status) |=> (status || !irq));

    p_gpe_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe_en && !status) |=> (!status || gpe_assert_req));

    p_gpe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(gpe_assert_req && gpe_deassert_req));

    p_gpe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !gpe_en |=> !(gpe_assert_req || gpe_deassert_req));
endmodule

bind pme_status_tracker pme_status_checker u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .int_en           (int_en),
    .gpe_en           (gpe_en),
    .status           (status_bit),
    .pending          (pending_bit),
    .irq              (irq),
    .gpe_assert_req   (gpe_assert_req),
    .gpe_deassert_req (gpe_deassert_req),
    .overflow         (overflow),
    .reg_rdata        (reg_rdata)
);

// File: tb/pme_status_tracker_bench.sv
`timescale 1ns/1ps
module pme_status_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [15:0] evt_rid = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        int_en = 1'b0;
    logic        gpe_en = 1'b0;
    logic        irq, gpe_assert_req, gpe_deassert_req, overflow;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pme_status_tracker u_pme_status_tracker (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_rid(evt_rid),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .int_en(int_en), .gpe_en(gpe_en), .irq(irq),
        .gpe_assert_req(gpe_assert_req), .gpe_deassert_req(gpe_deassert_req),
        .overflow(overflow)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic idle();
        @(negedge clk);
    endtask

    task automatic send_evt(input logic [15:0] rid);
        evt_valid = 1'b1; evt_rid = rid;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic wr(input logic [31:0] data);
        reg_wr = 1'b1; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic clr_with_evt(input logic [15:0] rid);
        reg_wr = 1'b1; reg_wdata = 32'h0001_0000; evt_valid = 1'b1; evt_rid = rid;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; evt_valid = 1'b0;
    endtask

    // driver: push expected read value into the scoreboard
    task automatic rd(input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // monitor: pop and compare one cycle after each read strobe
    always @(posedge clk) begin
        if (reg_rd) begin
            #1;
            if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
            else chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 outputs", {28'h0, irq, gpe_assert_req, gpe_deassert_req, overflow}, 32'h0);
        rd(32'h0, "R1 read");

        int_en = 1'b1; gpe_en = 1'b1;
        send_evt(16'h1234);
        chk("R11 assert pulse", {31'h0, gpe_assert_req}, 32'h1);
        chk("R10 irq rise", {31'h0, irq}, 32'h1);
        idle();
        chk("R11 pulse one cycle", {31'h0, gpe_assert_req}, 32'h0);
        rd(32'h0001_1234, "R3 R2 first event");

        send_evt(16'hAAAA);
        send_evt(16'hBBBB);
        rd(32'h0003_1234, "R4 queued, id kept");
        wr(32'hFFFE_FFFF);
        rd(32'h0003_1234, "R5 zero to bit16 ignored");

        wr(32'h0001_0000);
        chk("R6 status low", {31'h0, irq}, 32'h0);
        chk("R11 deassert pulse", {31'h0, gpe_deassert_req}, 32'h1);
        idle();
        chk("R6 re-set assert pulse", {30'h0, gpe_assert_req, irq}, 32'h3);
        rd(32'h0003_AAAA, "R6 oldest first");
        wr(32'h0001_0000);
        idle();
        rd(32'h0001_BBBB, "R7 pending cleared");

        for (int i = 0; i < 5; i++) send_evt(16'hC000 + 16'(i));
        chk("R8 overflow set", {31'h0, overflow}, 32'h1);
        rd(32'h0003_BBBB, "R8 queue full");
        for (int i = 0; i < 4; i++) begin
            wr(32'h0001_0000);
            idle();
            rd({14'h0, (i < 3), 1'b1, 16'hC000 + 16'(i)}, "R8 R6 delivery order");
        end
        chk("R8 overflow sticky", {31'h0, overflow}, 32'h1);
        wr(32'h0001_0000);
        rd(32'h0000_C003, "R5 cleared, empty");

        send_evt(16'h5555);
        rd(32'h0001_5555, "R3 direct event");
        clr_with_evt(16'h6666);
        chk("R9 deassert pulse", {31'h0, gpe_deassert_req}, 32'h1);
        rd(32'h0000_6666, "R9 one low cycle, not pending");
        rd(32'h0001_6666, "R9 reported");

        int_en = 1'b0; gpe_en = 1'b0;
        wr(32'h0001_0000);
        chk("R10 irq held when disabled", {31'h0, irq}, 32'h1);
        chk("R11 no deassert when disabled", {31'h0, gpe_deassert_req}, 32'h0);
        send_evt(16'h7777);
        chk("R11 no assert when disabled", {31'h0, gpe_assert_req}, 32'h0);
        rd(32'h0001_7777, "R3 event after disable");

        idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule